// File: doc/BRIEF.md
# E1 Red Alarm Detector

This block decides whether an E1 receiver is in the loss-of-frame (red alarm) condition. It listens to a per-frame strobe that marks each frame alignment word slot, a flag saying whether that word was correct, and a raw loss-of-frame indication from the framer. It drives an alarm level, a one-cycle change pulse and a gated interrupt line.

A mode input picks one of two detection methods. In direct mode, the alarm follows runs of alignment words. A run of bad words at least as long as a programmable threshold sets the alarm. A run of two good words clears it. In integrating mode, time is cut into 4 ms intervals of 32 frames. Each interval is flagged if raw loss-of-frame was seen during it. A saturating up/down counter rises on flagged intervals and falls on clean ones. The alarm sets when the counter reaches 25 and drops only when the counter returns to zero. Switching mode restarts both detectors from a clear state.

Top module: `e1_red_alarm`

## Requirements
- R1: With `mode_i`=1 (direct), `alarm_o` goes high one cycle after the strobe that completes a run of consecutive bad words (`fas_ok_i`=0) equal to `fas_thr_i`. A threshold of 0 acts as 1.
- R2: In direct mode, a set alarm goes low one cycle after the second consecutive good word (`fas_ok_i`=1).
- R3: In direct mode, a good word restarts the bad-word run, and a bad word restarts the good-word run.
- R4: With `mode_i`=0 (integrating), an interval spans 32 strobes. It is flagged if `lof_i` is high in any clock cycle of it, including the cycle of its 32nd strobe.
- R5: The interval counter goes up by one per flagged interval and down by one per clean interval. It stays between 0 and 25.
- R6: In integrating mode, `alarm_o` sets in the cycle after the interval that brings the counter to 25. It clears only in the cycle after the interval that brings the counter to 0.
- R7: `chg_o` is high for exactly the one cycle after each change of `alarm_o`. `irq_o` equals `chg_o` AND `irq_en_i`.
- R8: A change of `mode_i` clears both detectors and the alarm at the next clock edge. Strobes in that cycle are ignored.
- R9: After reset, `alarm_o`, `chg_o` and `irq_o` are low.
- R10: Cycles without a strobe do not advance either the run counters or the frame count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 1 = direct run detection, 0 = interval integration |
| fas_stb_i | input | 1 | One-cycle strobe per frame alignment word slot |
| fas_ok_i | input | 1 | Alignment word correct, valid with the strobe |
| lof_i | input | 1 | Raw loss-of-frame indication, any cycle |
| fas_thr_i | input | THR_W | Bad-word run length that sets the alarm in direct mode |
| irq_en_i | input | 1 | Interrupt enable |
| alarm_o | output | 1 | Red alarm level |
| chg_o | output | 1 | One-cycle pulse after an alarm change |
| irq_o | output | 1 | Change pulse gated by the enable |

## Verification
The bench targets run breaks. A bad run cut one word short by a good word must not set the alarm. A single good word between bad words must not clear it. A design that forgot to reset one run counter would trip early or clear late. The bench also drives more than 25 flagged intervals and then exactly 24 clean ones. A counter that did not saturate would need extra clean intervals before the alarm clears. A design that cleared below the set level would drop the alarm too early. Loss of frame is raised only in the cycle of an interval's closing strobe, which exposes a design that clears its flag before sampling. A mode switch while the alarm is high must produce a clearing edge and a change pulse.

// File: rtl/e1ra_pkg.sv
package e1ra_pkg;
  typedef enum logic {
    MODE_INTEG  = 1'b0,
    MODE_DIRECT = 1'b1
  } det_mode_e;
endpackage

// File: rtl/e1ra_fas_run.sv
module e1ra_fas_run #(
  parameter int THR_W   = 4,
  parameter int CLR_RUN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             stb_i,
  input  logic             ok_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             defect_o
);
  localparam int GW = $clog2(CLR_RUN + 1);
  localparam logic [GW-1:0] GOOD_LIM = GW'(CLR_RUN);

  logic [THR_W-1:0] bad_q, bad_nxt, thr_eff;
  logic [GW-1:0]    good_q, good_nxt;
  logic             def_q, def_nxt;

  assign thr_eff = (thr_i == '0) ? THR_W'(1) : thr_i;

  always_comb begin
    bad_nxt  = bad_q;
    good_nxt = good_q;
    def_nxt  = def_q;
    if (clr_i) begin
      bad_nxt  = '0;
      good_nxt = '0;
      def_nxt  = 1'b0;
    end else if (en_i && stb_i) begin
      if (!ok_i) begin
        good_nxt = '0;
        if (bad_q != '1) bad_nxt = bad_q + 1'b1;
        if (bad_nxt >= thr_eff) def_nxt = 1'b1;
      end else begin
        bad_nxt = '0;
        if (good_q < GOOD_LIM) good_nxt = good_q + 1'b1;
        if (good_nxt >= GOOD_LIM) def_nxt = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bad_q  <= '0;
      good_q <= '0;
      def_q  <= 1'b0;
    end else begin
      bad_q  <= bad_nxt;
      good_q <= good_nxt;
      def_q  <= def_nxt;
    end
  end

  assign defect_o = def_q;
endmodule

// File: rtl/e1ra_interval.sv
module e1ra_interval #(
  parameter int FRAMES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic stb_i,
  input  logic lof_i,
  output logic end_o,
  output logic flag_o
);
  localparam int FW = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

  logic [FW-1:0] frm_q;
  logic          hit_q;

  assign end_o  = en_i && stb_i && (frm_q == LAST);
  assign flag_o = hit_q | lof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_q <= '0;
      hit_q <= 1'b0;
    end else if (clr_i) begin
      frm_q <= '0;
      hit_q <= 1'b0;
    end else if (en_i) begin
      if (end_o) begin
        frm_q <= '0;
        hit_q <= 1'b0;
      end else begin
        if (stb_i) frm_q <= frm_q + 1'b1;
        hit_q <= hit_q | lof_i;
      end
    end
  end
endmodule

// File: rtl/e1ra_integrator.sv
module e1ra_integrator #(
  parameter int SET_LVL = 25,
  parameter int CW      = $clog2(SET_LVL + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic          flag_i,
  output logic          alarm_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] TOP = CW'(SET_LVL);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          alm_q, alm_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    alm_nxt = alm_q;
    if (clr_i) begin
      cnt_nxt = '0;
      alm_nxt = 1'b0;
    end else if (tick_i) begin
      if (flag_i) begin
        if (cnt_q < TOP) cnt_nxt = cnt_q + 1'b1;
      end else if (cnt_q != '0) begin
        cnt_nxt = cnt_q - 1'b1;
      end
      if (cnt_nxt == TOP)      alm_nxt = 1'b1;
      else if (cnt_nxt == '0)  alm_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      alm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      alm_q <= alm_nxt;
    end
  end

  assign alarm_o = alm_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/e1_red_alarm.sv
module e1_red_alarm
  import e1ra_pkg::*;
#(
  parameter int THR_W   = 4,
  parameter int CLR_RUN = 2,
  parameter int FRAMES  = 32,
  parameter int SET_LVL = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             fas_stb_i,
  input  logic             fas_ok_i,
  input  logic             lof_i,
  input  logic [THR_W-1:0] fas_thr_i,
  input  logic             irq_en_i,
  output logic             alarm_o,
  output logic             chg_o,
  output logic             irq_o
);
  localparam int CW = $clog2(SET_LVL + 1);

  det_mode_e     mode_q;
  logic          mode_chg, dir_en, int_en;
  logic          dir_alarm, int_alarm, tick, flag, alarm_d_q;
  logic [CW-1:0] int_cnt;

  assign mode_chg = (det_mode_e'(mode_i) != mode_q);
  assign dir_en   = !mode_chg && (mode_q == MODE_DIRECT);
  assign int_en   = !mode_chg && (mode_q == MODE_INTEG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_INTEG;
      alarm_d_q <= 1'b0;
    end else begin
      mode_q    <= det_mode_e'(mode_i);
      alarm_d_q <= alarm_o;
    end
  end

  e1ra_fas_run #(.THR_W(THR_W), .CLR_RUN(CLR_RUN)) u_run (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(mode_chg), .en_i(dir_en),
    .stb_i(fas_stb_i), .ok_i(fas_ok_i), .thr_i(fas_thr_i), .defect_o(dir_alarm)
  );

  e1ra_interval #(.FRAMES(FRAMES)) u_ivl (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(mode_chg), .en_i(int_en),
    .stb_i(fas_stb_i), .lof_i(lof_i), .end_o(tick), .flag_o(flag)
  );

  e1ra_integrator #(.SET_LVL(SET_LVL), .CW(CW)) u_int (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(mode_chg), .tick_i(tick),
    .flag_i(flag), .alarm_o(int_alarm), .cnt_o(int_cnt)
  );

  // inactive engine is held clear, so OR selects the active one
  assign alarm_o = dir_alarm | int_alarm;
  assign chg_o   = alarm_o ^ alarm_d_q;
  assign irq_o   = chg_o & irq_en_i;
endmodule

// File: rtl/e1ra_chk.sv
module e1ra_chk #(
  parameter int SET_LVL = 25,
  parameter int CW      = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mode_i,
  input logic          mode_q,
  input logic          fas_stb_i,
  input logic          fas_ok_i,
  input logic          irq_en_i,
  input logic          alarm_o,
  input logic          chg_o,
  input logic          irq_o,
  input logic          dir_alarm,
  input logic          int_alarm,
  input logic [CW-1:0] int_cnt
);
  // R1
  dir_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dir_alarm) |-> $past(fas_stb_i && !fas_ok_i && mode_i));
  // R2
  dir_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dir_alarm) |-> ($past(fas_stb_i && fas_ok_i) || $past(mode_i != mode_q)));
  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_cnt <= CW'(SET_LVL));
  // R6
  int_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_alarm) |-> (int_cnt == CW'(SET_LVL)));
  // R6
  int_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_alarm) |-> (int_cnt == '0));
  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && chg_o));
  // R8
  mode_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != mode_q) |=> !alarm_o);
  // R10
  no_stb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fas_stb_i && (mode_i == mode_q)) |=> $stable(dir_alarm));
endmodule

bind e1_red_alarm e1ra_chk #(.SET_LVL(SET_LVL), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .mode_q(mode_q),
  .fas_stb_i(fas_stb_i), .fas_ok_i(fas_ok_i), .irq_en_i(irq_en_i),
  .alarm_o(alarm_o), .chg_o(chg_o), .irq_o(irq_o), .dir_alarm(dir_alarm),
  .int_alarm(int_alarm), .int_cnt(int_cnt)
);

// File: tb/sim_e1_red_alarm.sv
module sim_e1_red_alarm;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       mode = 1'b0, stb = 1'b0, ok = 1'b1, lof = 1'b0, irq_en = 1'b1;
  logic [3:0] thr = 4'd3;
  logic       alarm, chg, irq;
  int         n_chk = 0, n_fail = 0, cyc = 0;
  string      phase = "R9";

  always #5 clk = ~clk;

  e1_red_alarm u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .fas_stb_i(stb), .fas_ok_i(ok),
    .lof_i(lof), .fas_thr_i(thr), .irq_en_i(irq_en),
    .alarm_o(alarm), .chg_o(chg), .irq_o(irq)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference
  int m_mode = 0, m_bad = 0, m_good = 0, m_dir = 0, m_frm = 0, m_hit = 0;
  int m_cnt = 0, m_int = 0, m_prev = 0;

  always @(posedge clk) begin
    int th;
    cyc++;
    if (rst_n) begin
      m_prev = m_dir | m_int;
      if (int'(mode) != m_mode) begin
        m_bad = 0; m_good = 0; m_dir = 0; m_frm = 0; m_hit = 0; m_cnt = 0; m_int = 0;
      end else if (mode) begin
        th = (thr == 0) ? 1 : int'(thr);
        if (stb) begin
          if (!ok) begin
            m_good = 0; if (m_bad < 15) m_bad++;
            if (m_bad >= th) m_dir = 1;
          end else begin
            m_bad = 0; m_good++;
            if (m_good >= 2) m_dir = 0;
          end
        end
      end else begin
        if (stb && m_frm == 31) begin
          if (m_hit || lof) begin if (m_cnt < 25) m_cnt++; end
          else if (m_cnt > 0) m_cnt--;
          if (m_cnt == 25) m_int = 1; else if (m_cnt == 0) m_int = 0;
          m_frm = 0; m_hit = 0;
        end else begin
          if (stb) m_frm++;
          if (lof) m_hit = 1;
        end
      end
      m_mode = int'(mode);
      #2;
      chk({phase, " alarm"}, alarm, logic'(m_dir | m_int));
      chk("R7 chg", chg, logic'((m_dir | m_int) != m_prev));
      chk("R7 irq", irq, logic'(((m_dir | m_int) != m_prev) && irq_en));
    end
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic frame(logic f_ok, logic f_lof_mid, logic f_lof_stb);
    @(negedge clk); stb = 1'b1; ok = f_ok; lof = f_lof_stb;
    @(negedge clk); stb = 1'b0; lof = f_lof_mid;
    @(negedge clk); lof = 1'b0;
    @(negedge clk);
  endtask

  task automatic ivl(int n, logic mid, logic at_stb);
    for (int i = 0; i < n; i++)
      for (int f = 0; f < 32; f++)
        frame(1'b1, mid && (f == 9), at_stb && (f == 31));
  endtask

  task automatic set_mode(logic m);
    @(negedge clk); mode = m;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset alarm", alarm, 1'b0);
    chk("R9 reset chg", chg, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    phase = "R1";
    set_mode(1'b1);
    frame(0, 0, 0); frame(0, 0, 0);
    phase = "R3"; frame(1, 0, 0);
    chk("R3 run broken", alarm, 1'b0);
    phase = "R1";
    frame(0, 0, 0); frame(0, 0, 0);
    chk("R1 two bad", alarm, 1'b0);
    frame(0, 0, 0);
    chk("R1 third bad", alarm, 1'b1);
    phase = "R2";
    frame(1, 0, 0); frame(0, 0, 0); frame(1, 0, 0);
    chk("R3 good run broken", alarm, 1'b1);
    frame(1, 0, 0);
    chk("R2 two good", alarm, 1'b0);
    phase = "R10";
    repeat (20) @(negedge clk);
    chk("R10 idle", alarm, 1'b0);
    phase = "R1";
    thr = 4'd0; frame(0, 0, 0);
    chk("R1 thr0", alarm, 1'b1);
    frame(1, 0, 0); frame(1, 0, 0);
    thr = 4'd5; irq_en = 1'b0;
    for (int i = 0; i < 4; i++) frame(0, 0, 0);
    chk("R1 thr5 four", alarm, 1'b0);
    frame(0, 0, 0);
    chk("R1 thr5 five", alarm, 1'b1);
    irq_en = 1'b1;

    phase = "R8";
    set_mode(1'b0);
    chk("R8 clear on switch", alarm, 1'b0);

    phase = "R6";
    ivl(24, 1, 0);
    chk("R6 24 flagged", alarm, 1'b0);
    ivl(1, 1, 0);
    chk("R6 25 flagged", alarm, 1'b1);
    phase = "R5";
    ivl(5, 1, 0);
    ivl(24, 0, 0);
    chk("R5 saturated hold", alarm, 1'b1);
    ivl(1, 0, 0);
    chk("R6 clear at zero", alarm, 1'b0);
    ivl(3, 0, 0);
    chk("R5 floor", alarm, 1'b0);

    phase = "R4";
    ivl(24, 0, 1);
    chk("R4 closing lof 24", alarm, 1'b0);
    ivl(1, 0, 1);
    chk("R4 closing lof 25", alarm, 1'b1);

    phase = "R8";
    set_mode(1'b1);
    chk("R8 switch clears alarm", alarm, 1'b0);
    set_mode(1'b0);
    ivl(1, 0, 0);
    chk("R8 restart clean", alarm, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule